// File: doc/BRIEF.md
# Network Controller Command and Interrupt Unit

This unit holds the command register, the interrupt status and mask registers and the transmit-launch sequencer of a page-based Ethernet controller. A host writes registers through a single byte-wide write port. The controller counts as running whenever the stop bit of the last command written is clear; the start bit has no effect. The transmit byte count is loaded as two separate bytes. The remote DMA engine and the receive path sit outside this unit. They report events through one-cycle set pulses and through a flag that says whether the remote byte count is zero.

A running command with the transmit bit set starts a three-state sequencer: **IDLE → RESOLVE → ISSUE → IDLE**.
- **IDLE → RESOLVE** happens on a running command write that has the transmit bit set.
- **RESOLVE** forms the buffer byte address from the transmit page and folds it back into packet memory if needed. It then checks that the whole frame fits below the end of packet memory. **RESOLVE → ISSUE** is unconditional, and the send request registers on that edge.
- **ISSUE** is the cycle in which the one-cycle send request is visible. **ISSUE → IDLE** is unconditional, and completion is posted on that edge.

A single interrupt line is registered from the enabled, non-reset status bits.

Register offsets on `wr_addr`:
- 0: command
- 1: status, write one to clear
- 2: mask
- 3: transmit page
- 4: count low byte
- 5: count high byte

Command bits:
- bit 0: stop
- bit 1: start
- bit 2: transmit
- bit 3: remote read
- bit 4: remote write

Status bits:
- bit 0: packet received
- bit 1: transmit done
- bit 6: remote DMA done
- bit 7: reset indication

Packet memory spans byte addresses 0x4000 up to 0x8000 (exclusive) with the default parameters.

Top module: `nic_cmd_irq_ctrl`

## Requirements
- R1: After reset, status reads 0x80, command reads 0x01, and mask and transmit status read 0x00. `send_req` and `irq` are low.
- R2: `irq` goes high one clock after (status AND mask AND 0x7F) becomes non-zero, and low one clock after it becomes zero. Status bit 7 never raises `irq`.
- R3: A command write with bit 0 clear clears status bit 7 at that edge. A command write with bit 0 set leaves status bit 7 unchanged.
- R4: Writing offset 1 clears each status bit whose data bit is 1. A set event in the same cycle wins over the clear.
- R5: A pulse on `rx_pkt_set` sets status bit 0, and a pulse on `dma_done_set` sets status bit 6, at the next edge.
- R6: A command write with bit 0 clear, with bit 3 or bit 4 set, and with `rcnt_zero` high sets status bit 6 at that edge. The bit is not set when the stop bit is set or when `rcnt_zero` is low.
- R7: The transmit start address is the transmit page times 256. If that value is at or beyond the end of packet memory, the packet memory size is subtracted once. `send_req` is high for exactly one cycle, the second cycle after the launching command write. In that cycle `send_addr` is that start address and `send_len` is {count high, count low}.
- R8: `send_req` is not raised when start plus length exceeds the end of packet memory. A frame that ends exactly at the end of packet memory is sent.
- R9: On the edge after the send cycle, whether or not the frame was sent: transmit status becomes 0x01, status bit 1 is set, and command bit 2 is cleared.
- R10: A command write with the stop bit set and the transmit bit set starts no transmit. It changes neither transmit status nor status bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register offset |
| wr_data | input | 8 | Register write data |
| rcnt_zero | input | 1 | Remote byte count is currently zero |
| dma_done_set | input | 1 | Set pulse for the remote-DMA-done status bit |
| rx_pkt_set | input | 1 | Set pulse for the packet-received status bit |
| cmd | output | 8 | Stored command register |
| isr | output | 8 | Interrupt status register |
| imr | output | 8 | Interrupt mask register |
| tsr | output | 8 | Transmit status register |
| send_req | output | 1 | One-cycle request to send a frame |
| send_addr | output | 16 | Byte address of the frame to send |
| send_len | output | 16 | Byte length of the frame to send |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume the host does not issue a second launching command while the sequencer is outside IDLE. They also assume the host does not write the transmit page or count during RESOLVE. The bench keeps to this by running each transmit to completion before its next register write. Set pulses and write-one-to-clear writes are applied only as single-cycle events, so each edge's status change can be predicted from one operation. Random mask, event and clear patterns are mixed with directed address-folding and boundary-length cases.

// File: rtl/nic_ctrl_pkg.sv
package nic_ctrl_pkg;
    // register offsets
    localparam logic [3:0] RA_CMD     = 4'd0;
    localparam logic [3:0] RA_ISR     = 4'd1;
    localparam logic [3:0] RA_IMR     = 4'd2;
    localparam logic [3:0] RA_TPAGE   = 4'd3;
    localparam logic [3:0] RA_TCNT_LO = 4'd4;

    // command bit positions
    localparam int CB_STOP   = 0;
    localparam int CB_TRANS  = 2;
    localparam int CB_RREAD  = 3;
    localparam int CB_RWRITE = 4;

    // status bit positions
    localparam int IB_RX  = 0;
    localparam int IB_TX  = 1;
    localparam int IB_RDC = 6;
    localparam int IB_RST = 7;

    localparam logic [7:0] CMD_RESET_VAL = 8'h01;
    localparam logic [7:0] ISR_RESET_VAL = 8'h80;
    localparam logic [7:0] TSR_SENT      = 8'h01;
    localparam logic [7:0] IRQ_ENABLES   = 8'h7F;

    typedef enum logic [1:0] {
        XS_IDLE    = 2'd0,
        XS_RESOLVE = 2'd1,
        XS_ISSUE   = 2'd2
    } xmit_state_e;
endpackage

// File: rtl/nic_reg_bank.sv
module nic_reg_bank
    import nic_ctrl_pkg::*;
#(
    parameter int CNT_BYTES = 2,
    localparam int CNT_W = 8 * CNT_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             clear_trans,
    output logic [7:0]       cmd_q,
    output logic [7:0]       imr_q,
    output logic [7:0]       tpage_q,
    output logic [CNT_W-1:0] tcnt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CMD_RESET_VAL;
        end else if (wr_en && wr_addr == RA_CMD) begin
            cmd_q <= wr_data;
        end else if (clear_trans) begin
            cmd_q[CB_TRANS] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr_q   <= '0;
            tpage_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == RA_IMR)   imr_q   <= wr_data;
            if (wr_addr == RA_TPAGE) tpage_q <= wr_data;
        end
    end

    // one byte lane of the transmit count per consecutive offset
    for (genvar g = 0; g < CNT_BYTES; g++) begin : g_cnt_lane
        localparam logic [3:0] LANE_ADDR = RA_TCNT_LO + 4'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tcnt_q[8*g +: 8] <= '0;
            end else if (wr_en && wr_addr == LANE_ADDR) begin
                tcnt_q[8*g +: 8] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/nic_int_status.sv
module nic_int_status
    import nic_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_en,
    input  logic [7:0] clr_mask,
    input  logic       run_wr,
    input  logic       rx_set,
    input  logic       tx_set,
    input  logic       rdc_set,
    input  logic [7:0] imr_q,
    output logic [7:0] isr_q,
    output logic       irq
);
    logic [7:0] set_vec;
    logic [7:0] isr_next;

    always_comb begin
        set_vec          = '0;
        set_vec[IB_RX]   = rx_set;
        set_vec[IB_TX]   = tx_set;
        set_vec[IB_RDC]  = rdc_set;
        isr_next         = isr_q;
        if (clr_en) isr_next = isr_next & ~clr_mask;
        if (run_wr) isr_next[IB_RST] = 1'b0;
        isr_next = isr_next | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q <= ISR_RESET_VAL;
            irq   <= 1'b0;
        end else begin
            isr_q <= isr_next;
            irq   <= |(isr_q & imr_q & IRQ_ENABLES);
        end
    end
endmodule

// File: rtl/nic_xmit_fsm.sv
module nic_xmit_fsm
    import nic_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 16,
    parameter int PMEM_START = 16384,
    parameter int PMEM_SIZE  = 16384,
    localparam int SUM_W     = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2,
    localparam int PMEM_END  = PMEM_START + PMEM_SIZE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [7:0]        tpage,
    input  logic [LEN_W-1:0]  tcnt,
    output logic              done,
    output logic              send_req,
    output logic [ADDR_W-1:0] send_addr,
    output logic [LEN_W-1:0]  send_len,
    output logic [7:0]        tsr
);
    localparam logic [SUM_W-1:0] END_X  = SUM_W'(PMEM_END);
    localparam logic [SUM_W-1:0] SIZE_X = SUM_W'(PMEM_SIZE);

    xmit_state_e state_q, state_d;
    logic [SUM_W-1:0] raw_start, adj_start;
    logic             fits;

    always_comb begin
        raw_start = SUM_W'({tpage, 8'h00});
        adj_start = (raw_start >= END_X) ? raw_start - SIZE_X : raw_start;
        fits      = (adj_start + SUM_W'(tcnt)) <= END_X;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:    if (launch) state_d = XS_RESOLVE;
            XS_RESOLVE: state_d = XS_ISSUE;
            XS_ISSUE:   state_d = XS_IDLE;
            default:    state_d = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            send_req  <= 1'b0;
            send_addr <= '0;
            send_len  <= '0;
            tsr       <= '0;
        end else begin
            send_req <= 1'b0;
            if (state_q == XS_RESOLVE) begin
                send_req  <= fits;
                send_addr <= adj_start[ADDR_W-1:0];
                send_len  <= tcnt;
            end
            if (state_q == XS_ISSUE) tsr <= TSR_SENT;
        end
    end

    assign done = (state_q == XS_ISSUE);
endmodule

// File: rtl/nic_cmd_irq_ctrl.sv
module nic_cmd_irq_ctrl
    import nic_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_BYTES  = 2,
    parameter int PMEM_START = 16384,
    parameter int PMEM_SIZE  = 16384,
    localparam int LEN_W     = 8 * CNT_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rcnt_zero,
    input  logic              dma_done_set,
    input  logic              rx_pkt_set,
    output logic [7:0]        cmd,
    output logic [7:0]        isr,
    output logic [7:0]        imr,
    output logic [7:0]        tsr,
    output logic              send_req,
    output logic [ADDR_W-1:0] send_addr,
    output logic [LEN_W-1:0]  send_len,
    output logic              irq
);
    logic             run_wr, launch, xmit_done, rdc_any, clr_en;
    logic [7:0]       tpage;
    logic [LEN_W-1:0] tcnt;

    assign run_wr  = wr_en && wr_addr == RA_CMD && !wr_data[CB_STOP];
    assign launch  = run_wr && wr_data[CB_TRANS];
    assign rdc_any = dma_done_set
                   || (run_wr && rcnt_zero && (wr_data[CB_RREAD] || wr_data[CB_RWRITE]));
    assign clr_en  = wr_en && wr_addr == RA_ISR;

    nic_reg_bank #(.CNT_BYTES(CNT_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clear_trans(xmit_done), .cmd_q(cmd),
        .imr_q(imr), .tpage_q(tpage), .tcnt_q(tcnt)
    );

    nic_int_status u_status (
        .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .clr_mask(wr_data),
        .run_wr(run_wr), .rx_set(rx_pkt_set), .tx_set(xmit_done),
        .rdc_set(rdc_any), .imr_q(imr), .isr_q(isr), .irq(irq)
    );

    nic_xmit_fsm #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W),
        .PMEM_START(PMEM_START), .PMEM_SIZE(PMEM_SIZE)
    ) u_xmit (
        .clk(clk), .rst_n(rst_n), .launch(launch), .tpage(tpage),
        .tcnt(tcnt), .done(xmit_done), .send_req(send_req),
        .send_addr(send_addr), .send_len(send_len), .tsr(tsr)
    );
endmodule

// File: rtl/nic_cmd_irq_chk.sv
module nic_cmd_irq_chk #(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 16,
    parameter int PMEM_END = 32768
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [7:0]        wr_data,
    input logic              dma_done_set,
    input logic              rx_pkt_set,
    input logic [7:0]        isr,
    input logic [7:0]        imr,
    input logic              irq,
    input logic              send_req,
    input logic [ADDR_W-1:0] send_addr,
    input logic [LEN_W-1:0]  send_len
);
    // R2
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr & imr & 8'h7F) != 8'h00) |=> irq);
    // R2
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr & imr & 8'h7F) == 8'h00) |=> !irq);
    // R3
    run_clears_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd0 && !wr_data[0]) |=> !isr[7]);
    // R5
    rdc_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done_set |=> isr[6]);
    // R5
    rx_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pkt_set |=> isr[0]);
    // R7
    send_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_req |=> !send_req);
    // R8
    send_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_req |-> (32'(send_addr) + 32'(send_len) <= 32'(PMEM_END)));
    // R9
    send_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_req |=> isr[1]);
endmodule

bind nic_cmd_irq_ctrl nic_cmd_irq_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PMEM_END(PMEM_START + PMEM_SIZE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dma_done_set(dma_done_set), .rx_pkt_set(rx_pkt_set),
    .isr(isr), .imr(imr), .irq(irq), .send_req(send_req),
    .send_addr(send_addr), .send_len(send_len)
);

// File: tb/tb_nic_cmd_irq_ctrl.sv
module tb_nic_cmd_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PSTART     = 16384;
    localparam int PSIZE      = 16384;
    localparam int PEND       = PSTART + PSIZE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rcnt_zero = 1'b0;
    logic        dma_done_set = 1'b0;
    logic        rx_pkt_set = 1'b0;
    logic [7:0]  cmd, isr, imr, tsr;
    logic        send_req, irq;
    logic [15:0] send_addr, send_len;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] m_isr, m_imr;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_cmd_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rcnt_zero(rcnt_zero), .dma_done_set(dma_done_set),
        .rx_pkt_set(rx_pkt_set), .cmd(cmd), .isr(isr), .imr(imr), .tsr(tsr),
        .send_req(send_req), .send_addr(send_addr), .send_len(send_len),
        .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_start(input logic [7:0] tp);
        int s = int'(tp) * 256;
        if (s >= PEND) s = s - PSIZE;
        return s;
    endfunction

    function automatic bit exp_fits(input logic [7:0] tp, input int len);
        return (exp_start(tp) + len) <= PEND;
    endfunction

    function automatic bit exp_irq();
        return |(m_isr & m_imr & 8'h7F);
    endfunction

    // called at a negedge, returns at the negedge after the write edge
    task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input bit rx, input bit dma);
        rx_pkt_set = rx; dma_done_set = dma;
        @(negedge clk);
        rx_pkt_set = 1'b0; dma_done_set = 1'b0;
    endtask

    task automatic do_xmit(input logic [7:0] tp, input int len, input logic [7:0] cv);
        bit f;
        reg_wr(4'd3, tp);
        reg_wr(4'd4, len[7:0]);
        reg_wr(4'd5, len[15:8]);
        reg_wr(4'd0, cv);
        m_isr[7] = 1'b0;
        f = exp_fits(tp, len);
        @(negedge clk);
        chk("R8", "send_req in send cycle", int'(send_req), int'(f));
        if (f) begin
            chk("R7", "send_addr", int'(send_addr), exp_start(tp));
            chk("R7", "send_len", int'(send_len), len);
        end
        @(negedge clk);
        chk("R7", "send_req one cycle", int'(send_req), 0);
        chk("R9", "tsr after transmit", int'(tsr), 8'h01);
        m_isr[1] = 1'b1;
        chk("R9", "isr tx bit", int'(isr), int'(m_isr));
        chk("R9", "cmd trans cleared", int'(cmd), int'(cv & 8'hFB));
        reg_wr(4'd1, 8'h02);
        m_isr[1] = 1'b0;
    endtask

    task automatic irq_chk(input string req);
        @(negedge clk);
        chk(req, "irq", int'(irq), int'(exp_irq()));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] tp;
        int len;
        void'($urandom(32'h1A2B3C));
        m_isr = 8'h80; m_imr = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "isr", int'(isr), 8'h80);
        chk("R1", "cmd", int'(cmd), 8'h01);
        chk("R1", "imr", int'(imr), 0);
        chk("R1", "tsr", int'(tsr), 0);
        chk("R1", "send_req", int'(send_req), 0);
        chk("R1", "irq", int'(irq), 0);

        // R2 bit 7 enabled in the mask never raises irq
        reg_wr(4'd2, 8'h80); m_imr = 8'h80;
        irq_chk("R2");

        // R10 stop plus trans does nothing; R3 stop write keeps reset bit
        reg_wr(4'd0, 8'h05);
        chk("R10", "send_req", int'(send_req), 0);
        @(negedge clk);
        chk("R10", "send_req later", int'(send_req), 0);
        @(negedge clk);
        chk("R10", "tsr", int'(tsr), 0);
        chk("R10", "cmd", int'(cmd), 8'h05);
        chk("R3", "isr with stop write", int'(isr), 8'h80);

        // R6 stopped remote read with zero count: no completion
        rcnt_zero = 1'b1;
        reg_wr(4'd0, 8'h09);
        chk("R6", "isr stopped remote", int'(isr), 8'h80);
        // R6 running remote read with zero count; R3 reset bit cleared
        reg_wr(4'd0, 8'h0A);
        m_isr = 8'h40;
        chk("R6", "isr running remote read", int'(isr), 8'h40);
        reg_wr(4'd1, 8'h40); m_isr = 8'h00;
        chk("R4", "isr after clear", int'(isr), 0);
        rcnt_zero = 1'b0;
        reg_wr(4'd0, 8'h12);
        chk("R6", "nonzero count remote write", int'(isr), 0);
        rcnt_zero = 1'b1;
        reg_wr(4'd0, 8'h12);
        chk("R6", "zero count remote write", int'(isr), 8'h40);
        rcnt_zero = 1'b0;
        reg_wr(4'd1, 8'hFF); m_isr = 8'h00;
        chk("R4", "clear all", int'(isr), 0);

        // R4 set wins over clear in the same cycle
        rx_pkt_set = 1'b1;
        reg_wr(4'd1, 8'h01);
        rx_pkt_set = 1'b0;
        m_isr[0] = 1'b1;
        chk("R4", "set beats clear", int'(isr), int'(m_isr));
        // R5 remote DMA event
        pulse(1'b0, 1'b1); m_isr[6] = 1'b1;
        chk("R5", "dma event", int'(isr), int'(m_isr));
        reg_wr(4'd2, 8'h40); m_imr = 8'h40;
        irq_chk("R2");
        reg_wr(4'd1, 8'h41); m_isr = 8'h00;
        irq_chk("R2");

        // directed transmits: folding and boundaries (R7, R8, R9)
        do_xmit(8'h40, 16'h0100, 8'h06);
        do_xmit(8'h80, 16'h003C, 8'h06);
        do_xmit(8'h7F, 16'h0100, 8'h06);
        do_xmit(8'h7F, 16'h0101, 8'h06);
        do_xmit(8'hC0, 16'h0000, 8'h04);
        do_xmit(8'hFF, 16'h0010, 8'h06);
        do_xmit(8'h00, 16'h0040, 8'h06);

        // random mask, event and clear mix (R2, R4, R5)
        for (int i = 0; i < 60; i++) begin
            int op = $urandom_range(0, 2);
            if (op == 0) begin
                tp = 8'($urandom);
                reg_wr(4'd2, tp); m_imr = tp;
            end else if (op == 1) begin
                bit rx = 1'($urandom);
                bit dm = 1'($urandom);
                pulse(rx, dm);
                if (rx) m_isr[0] = 1'b1;
                if (dm) m_isr[6] = 1'b1;
                chk("R5", "isr after events", int'(isr), int'(m_isr));
            end else begin
                tp = 8'($urandom);
                reg_wr(4'd1, tp); m_isr = m_isr & ~tp;
                chk("R4", "isr after clear", int'(isr), int'(m_isr));
            end
            irq_chk("R2");
        end
        reg_wr(4'd1, 8'hFF); m_isr = 8'h00;

        // random transmits (R7, R8, R9)
        for (int i = 0; i < 40; i++) begin
            tp  = 8'($urandom);
            len = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 16'hFFFF))
                                             : int'($urandom_range(0, 16'h07FF));
            do_xmit(tp, len, 8'h06);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule